// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host read a fixed table of small configuration items over a register interface. The host first writes a 16-bit key to pick an item, then reads the item through a data port, one to eight bytes per access. An internal byte offset remembers how far the host has read. Each data access returns the next bytes of the item with the first byte in the most significant lane of the returned value. Once the item runs out, the remaining lanes read as zero and the offset stops moving.

The key holds a bank flag and an index. The bank flag picks one of two item tables, a generic one and an architecture-local one. The index picks the item within that table. The table contents are computed at elaboration from parameters, and nothing can write them.

A parameter picks one of two access mappings. The split mapping has a control port that takes only key writes and a data port that takes reads. The combined mapping uses one port: the access size tells a byte read from a key write.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the selected item is generic index 0, the signature. It holds the bytes 0x43, 0x46, 0x47, 0x21 and the offset is 0, so a 4-byte read returns 0x43464721. rdValid is 0 while no access is made.
- R2: Every accepted key write sets the offset back to 0, whether the key is valid or not. Selecting the current item again restarts it.
- R3: Key bit 14 picks the bank (0 generic, 1 architecture-local). Key bits 13:0 are the index within the bank.
- R4: An index at or above ENTRIES (8) makes the selection invalid. Every data read then returns 0 until a valid key is written.
- R5: A data read of N bytes (accSize = N, 1 to 8) returns the item bytes starting at the offset. The first byte sits in bits [8N-1:8N-8] and bits above 8N are 0. The offset then advances by N.
- R6: If the item ends during an N-byte read, the low-order lanes past the end read 0. The offset stops at the item length.
- R7: A read with the offset at or past the item length, or of an empty item (generic index 2, length 0), returns 0 and leaves the offset unchanged.
- R8: In the split mapping (accPort 0 control, 1 data) the control port acts only on 2-byte writes. Control reads return 0. Writes to the data port change neither the item nor the offset. No write ever raises rdValid.
- R9: In the combined mapping, a 1-byte read is a data read and a 2-byte write is a key write. A 2-byte read returns 0 and a 1-byte write is ignored; neither disturbs the offset.
- R10: Generic index 1 is the identity item: 4 bytes, little-endian value with bit 0 set and bit 1 equal to DMA_PRESENT (default 0). A 4-byte read returns 0x01000000.
- R11: A read whose size is 0 or above 8 returns 0 with rdValid 1, and the offset is unchanged. Every read gets rdValid exactly one cycle after the access.
- R12: Every other item (bank b, index i, apart from generic 0 to 2) has length 2*i+b bytes, and its byte j is {b, i[2:0], j[3:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe, one cycle per access |
| accWrite | input | 1 | 1 write, 0 read |
| accPort | input | 1 | Split mapping: 0 control, 1 data; ignored when combined |
| accSize | input | 4 | Access size in bytes |
| accWdata | input | 16 | Key value for key writes |
| rdValid | output | 1 | Read result valid, one cycle after a read access |
| rdData | output | 64 | Read result, zero when rdValid is low |

## Verification
The assertions assume that accValid is a single-cycle strobe per access and that accSize and accWdata are stable while it is high. The bench drives each access for exactly one clock and then drops accValid for a clock. The checks assume that the item lengths never exceed MAX_LEN, which the default table keeps. Keys outside the table, zero and oversized sizes, and the wrong port or size for a write are all driven on purpose, so that the reject paths are exercised in both mappings.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;
  localparam int KEY_W     = 16;
  localparam int ARCH_BIT  = 14;
  localparam int MAX_BYTES = 8;

  typedef struct packed {
    logic             sel;     // key write accepted
    logic             rd;      // data read accepted
    logic             rej;     // read rejected, answer zero
    logic [3:0]       nBytes;
    logic [KEY_W-1:0] key;
  } strobe_t;
endpackage

// File: rtl/cfg_item_ctrl.sv
module cfg_item_ctrl
  import cfg_item_pkg::*;
#(
  parameter bit COMBINED = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic             accPort,
  input  logic [3:0]       accSize,
  input  logic [KEY_W-1:0] accWdata,
  output strobe_t          strb
);
  logic sizeOk;
  logic unusedPort;
  assign sizeOk     = (accSize >= 4'd1) && (accSize <= 4'(MAX_BYTES));
  assign unusedPort = accPort;

  generate
    if (COMBINED) begin : g_comb
      always_comb begin
        strb        = '0;
        strb.sel    = accValid && accWrite && (accSize == 4'd2);
        strb.rd     = accValid && !accWrite && (accSize == 4'd1);
        strb.rej    = accValid && !accWrite && !(accSize == 4'd1);
        strb.nBytes = accSize;
        strb.key    = accWdata;
      end
    end else begin : g_split
      always_comb begin
        strb        = '0;
        strb.sel    = accValid && accWrite && !accPort && (accSize == 4'd2);
        strb.rd     = accValid && !accWrite && accPort && sizeOk;
        strb.rej    = accValid && !accWrite && !(accPort && sizeOk);
        strb.nBytes = accSize;
        strb.key    = accWdata;
      end
    end
  endgenerate

  // R9: at most one action per access
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sel, strb.rd, strb.rej}));
endmodule

// File: rtl/cfg_item_dpath.sv
module cfg_item_dpath
  import cfg_item_pkg::*;
#(
  parameter int          ENTRIES     = 8,
  parameter int          MAX_LEN     = 16,
  parameter logic [31:0] SIGNATURE   = 32'h43464721,
  parameter bit          DMA_PRESENT = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  output logic        rdValid,
  output logic [63:0] rdData
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int OFF_W = $clog2(MAX_LEN + 1);

  function automatic logic [OFF_W-1:0] lenOf(input logic bank, input logic [IDX_W-1:0] idx);
    int unsigned n;
    if (!bank && idx == 0)      n = 4;
    else if (!bank && idx == 1) n = 4;
    else if (!bank && idx == 2) n = 0;
    else                        n = 2 * int'(idx) + int'(bank);
    if (n > MAX_LEN) n = MAX_LEN;
    return OFF_W'(n);
  endfunction

  function automatic logic [7:0] byteOf(input logic bank, input logic [IDX_W-1:0] idx,
                                        input logic [OFF_W-1:0] pos);
    if (!bank && idx == 0) return SIGNATURE[8*(3-int'(pos[1:0])) +: 8];
    if (!bank && idx == 1) return (pos == 0) ? {6'd0, DMA_PRESENT, 1'b1} : 8'd0;
    return {bank, 3'(idx), 4'(pos)};
  endfunction

  logic             curValid, curBank;
  logic [IDX_W-1:0] curIdx;
  logic [OFF_W-1:0] offset, curLen, avail, take;
  logic [63:0]      rdNext;
  logic             keyOk;

  assign keyOk = int'(strb.key[ARCH_BIT-1:0]) < ENTRIES;

  always_comb begin
    curLen = curValid ? lenOf(curBank, curIdx) : '0;
    avail  = (offset < curLen) ? curLen - offset : '0;
    take   = (OFF_W'(strb.nBytes) < avail) ? OFF_W'(strb.nBytes) : avail;
    rdNext = '0;
    for (int k = 0; k < MAX_BYTES; k++) begin
      logic [7:0] lane;
      lane = (k < int'(take)) ? byteOf(curBank, curIdx, offset + OFF_W'(k)) : 8'd0;
      if (k < int'(strb.nBytes))
        rdNext = rdNext | (64'(lane) << (8 * (int'(strb.nBytes) - 1 - k)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curValid <= 1'b1;
      curBank  <= 1'b0;
      curIdx   <= '0;
      offset   <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      rdValid <= strb.rd | strb.rej;
      rdData  <= strb.rd ? rdNext : '0;
      if (strb.sel) begin
        curValid <= keyOk;
        curBank  <= strb.key[ARCH_BIT];
        curIdx   <= IDX_W'(strb.key[ARCH_BIT-1:0]);
        offset   <= '0;
      end else if (strb.rd) begin
        offset <= offset + take;
      end
    end
  end

  // R2: any key write restarts the offset
  p_sel_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.sel |=> offset == '0);
  // R4: reads of an invalid selection are zero
  p_invalid_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && !curValid) |=> rdData == '0);
  // R7: offset never passes the item end
  p_offset_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    offset <= curLen);
  // R8: no accepted action leaves the selection untouched
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sel && !strb.rd) |=> ($stable(offset) && $stable(curValid) && $stable(curIdx)));
  // R11: rejected reads answer zero
  p_reject_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.rej |=> (rdValid && rdData == '0));
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfg_item_pkg::*;
#(
  parameter bit          COMBINED    = 1'b0,
  parameter int          ENTRIES     = 8,
  parameter int          MAX_LEN     = 16,
  parameter logic [31:0] SIGNATURE   = 32'h43464721,
  parameter bit          DMA_PRESENT = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic        accPort,
  input  logic [3:0]  accSize,
  input  logic [15:0] accWdata,
  output logic        rdValid,
  output logic [63:0] rdData
);
  strobe_t strb;

  cfg_item_ctrl #(.COMBINED(COMBINED)) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accPort(accPort), .accSize(accSize), .accWdata(accWdata), .strb(strb));

  cfg_item_dpath #(.ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN), .SIGNATURE(SIGNATURE),
                   .DMA_PRESENT(DMA_PRESENT)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdValid(rdValid), .rdData(rdData));

  // R8: a write never produces read data
  p_write_no_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite) |=> !rdValid);
endmodule

// File: tb/tb_cfg_item_port.sv
`timescale 1ns/1ps
module tb_cfg_item_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vA = 1'b0, vB = 1'b0, wr = 1'b0, port = 1'b0;
  logic [3:0] size = '0;
  logic [15:0] wd = '0;
  logic rvA, rvB;
  logic [63:0] rdA, rdB;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_item_port #(.COMBINED(1'b0)) dut (
    .clk(clk), .rstN(rstN), .accValid(vA), .accWrite(wr), .accPort(port),
    .accSize(size), .accWdata(wd), .rdValid(rvA), .rdData(rdA));
  cfg_item_port #(.COMBINED(1'b1)) dutComb (
    .clk(clk), .rstN(rstN), .accValid(vB), .accWrite(wr), .accPort(port),
    .accSize(size), .accWdata(wd), .rdValid(rvB), .rdData(rdB));

  // behavioural reference state, one slot per instance
  int mValid[2], mBank[2], mIdx[2], mOff[2];

  function automatic int mLen(int b, int i);
    if (b == 0 && i == 0) return 4;
    if (b == 0 && i == 1) return 4;
    if (b == 0 && i == 2) return 0;
    return 2 * i + b;
  endfunction

  function automatic logic [7:0] mByte(int b, int i, int j);
    string s = "CFG!";
    if (b == 0 && i == 0) return s[j];
    if (b == 0 && i == 1) return (j == 0) ? 8'h01 : 8'h00;
    return 8'(b * 128 + i * 16 + j);
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(int inst, bit w, bit p, int sz, logic [15:0] key, string tag,
                     output logic [63:0] got);
    bit isSel, isRd, expV;
    logic [63:0] expD;
    isSel = 0; isRd = 0; expD = '0; expV = !w;
    if (inst == 0) begin
      if (!p) isSel = w && sz == 2;
      else    isRd  = !w && sz >= 1 && sz <= 8;
    end else begin
      isSel = w && sz == 2;
      isRd  = !w && sz == 1;
    end
    if (isSel) begin
      mValid[inst] = (key[13:0] < 8) ? 1 : 0;
      mBank[inst]  = key[14];
      mIdx[inst]   = key[13:0];
      mOff[inst]   = 0;
    end
    if (isRd) begin
      for (int k = 0; k < sz; k++) begin
        logic [7:0] b;
        b = 8'h00;
        if (mValid[inst] != 0 && mOff[inst] < mLen(mBank[inst], mIdx[inst])) begin
          b = mByte(mBank[inst], mIdx[inst], mOff[inst]);
          mOff[inst]++;
        end
        expD = (expD << 8) | 64'(b);
      end
    end
    @(negedge clk);
    wr = w; port = p; size = 4'(sz); wd = key;
    if (inst == 0) vA = 1'b1; else vB = 1'b1;
    @(negedge clk);
    vA = 1'b0; vB = 1'b0;
    got = (inst == 0) ? rdA : rdB;
    chk({tag, " valid"}, 64'((inst == 0) ? rvA : rvB), 64'(expV));
    chk({tag, " model"}, got, expD);
  endtask

  task automatic rd(int inst, int sz, logic [63:0] lit, string tag);
    logic [63:0] g;
    acc(inst, 0, 1, sz, 16'h0, tag, g);
    chk({tag, " literal"}, g, lit);
  endtask

  task automatic sel(int inst, logic [15:0] key, string tag);
    logic [63:0] g;
    acc(inst, 1, 0, 2, key, tag, g);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] g;
    for (int n = 0; n < 2; n++) begin
      mValid[n] = 1; mBank[n] = 0; mIdx[n] = 0; mOff[n] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset idle valid", 64'(rvA), 64'd0);
    chk("R1 reset idle data", rdA, 64'd0);
    // split mapping
    rd(0, 4, 64'h43464721, "R1 signature");
    rd(0, 1, 64'h0, "R7 past end");
    sel(0, 16'h0000, "R2 reselect");
    rd(0, 2, 64'h4346, "R5 two bytes");
    rd(0, 3, 64'h472100, "R6 padded tail");
    sel(0, 16'h0001, "R10 id select");
    rd(0, 4, 64'h01000000, "R10 id value");
    sel(0, 16'h0002, "R7 empty select");
    rd(0, 8, 64'h0, "R7 empty item");
    sel(0, 16'h4003, "R3 arch bank");
    rd(0, 8, 64'hB0B1B2B3B4B5B600, "R12 arch item");
    sel(0, 16'h0003, "R3 generic bank");
    rd(0, 2, 64'h3031, "R5 first pair");
    acc(0, 1, 1, 1, 16'h0005, "R8 data write", g);
    acc(0, 1, 0, 1, 16'h0005, "R8 ctl byte write", g);
    acc(0, 0, 0, 2, 16'h0, "R8 ctl read", g);
    chk("R8 ctl read zero", g, 64'h0);
    rd(0, 2, 64'h3233, "R8 offset kept");
    sel(0, 16'h0003, "R2 restart");
    rd(0, 1, 64'h30, "R2 from zero");
    acc(0, 0, 1, 0, 16'h0, "R11 size zero", g);
    acc(0, 0, 1, 9, 16'h0, "R11 size nine", g);
    chk("R11 oversize zero", g, 64'h0);
    rd(0, 1, 64'h31, "R11 offset kept");
    sel(0, 16'h0008, "R4 index eight");
    rd(0, 4, 64'h0, "R4 invalid read");
    sel(0, 16'h5000, "R4 arch invalid");
    rd(0, 8, 64'h0, "R4 invalid arch read");
    sel(0, 16'h0007, "R2 valid after invalid");
    rd(0, 8, 64'h7071727374757677, "R5 eight bytes");
    rd(0, 8, 64'h78797A7B7C7D0000, "R6 tail pad");
    rd(0, 8, 64'h0, "R7 exhausted");
    // combined mapping
    rd(1, 1, 64'h43, "R9 comb byte0");
    rd(1, 1, 64'h46, "R9 comb byte1");
    sel(1, 16'h4005, "R9 comb select");
    rd(1, 1, 64'hD0, "R12 comb arch item");
    acc(1, 0, 0, 2, 16'h0, "R9 comb word read", g);
    chk("R9 word read zero", g, 64'h0);
    acc(1, 1, 0, 1, 16'h0001, "R9 comb byte write", g);
    acc(1, 0, 0, 4, 16'h0, "R11 comb size four", g);
    rd(1, 1, 64'hD1, "R9 offset kept");
    sel(1, 16'h0001, "R10 comb id");
    rd(1, 1, 64'h01, "R10 comb id byte");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule